// File: doc/BRIEF.md
# BF16 Immediate Float Expander

This block sits in the decode path of a floating-point unit. It accepts a 32-bit instruction word that carries a 16-bit brain-float (BF16) constant and produces the 64-bit double-precision value that will be written to a floating-point register. The immediate is split across two fields of the word that are not next to each other. The block puts the two parts back together, appends sixteen zero bits to form a single-precision number, and then widens that single to double precision. Zeros, normals, subnormals, infinities and NaNs are all converted exactly.

An instruction is accepted only when its major and extended opcode fields equal a configured pair. The result is registered. The result valid and the destination register index appear one clock after the accepted instruction. With this block, a floating-point register can be loaded with a constant such as 0.0, ±1.0, ±infinity or a quiet NaN in one instruction, without a memory access.

Top module: `bfimm_expander`

## Requirements
- R1: Bits are numbered MSB-0 (bit 0 is `insn_word[31]`). The major opcode is `insn_word[31:26]` and the extended opcode is `insn_word[5:1]`. When `insn_valid` is high and these fields equal `MAJOR_OP` (default 59) and `EXT_OP` (default 22), `res_valid` is high on the next clock.
- R2: When `insn_valid` is low, or either opcode field does not match, `res_valid` is low on the next clock and `res_value` and `res_fpr` keep their previous values.
- R3: `res_fpr` carries the destination field `insn_word[25:21]` of the accepted instruction.
- R4: The immediate is `{insn_word[0], insn_word[20:6]}`, so `insn_word[0]` is its most significant bit and gives the sign of the result. The single-precision value is the immediate shifted left by 16.
- R5: For a normal single, the double exponent is the single exponent plus 896, and the 23 fraction bits fill the top of the 52-bit double fraction. Examples: 0x3F80 gives 0x3FF0000000000000, 0xBFC0 gives 0xBFF8000000000000, and 0x3FFF gives 0x3FFFE00000000000.
- R6: 0x0000 gives 0x0000000000000000 and 0x8000 gives 0x8000000000000000.
- R7: A subnormal single (exponent zero, fraction nonzero) with leading-zero count z is normalised. The double exponent becomes 896 − z and the fraction is shifted left by z+1. Examples: 0x0040 gives 0x3800000000000000 and 0x0001 gives 0x37A0000000000000.
- R8: 0x7F80 gives 0x7FF0000000000000 and 0xFF80 gives 0xFFF0000000000000.
- R9: A NaN keeps its sign and its fraction bits, left-aligned, and is not quieted. 0x7FC0 gives 0x7FF8000000000000 and 0x7F81 gives 0x7FF0200000000000.
- R10: While `rst` is high, on the next clock `res_valid`, `res_fpr` and `res_value` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| res_valid | output | 1 | Result is valid this cycle |
| res_fpr | output | 5 | Destination floating-point register index |
| res_value | output | 64 | Expanded double-precision value |

## Verification
The subnormal path is the hardest to reach. Only immediates with a zero exponent field and a nonzero fraction drive it. Because the lower sixteen single-precision fraction bits are always zero, the leading-zero count can only take the values 0 through 6. The stimulus table therefore includes immediates at both ends of that range (0x0040 and 0x0001) and a mixed pattern with a negative sign (0x8041). Each of these is placed in a word with the immediate's top bit in the far bit 0, so that a mistake in the field reassembly also shows up.

// File: rtl/bfimm_pkg.sv
package bfimm_pkg;

    localparam int INSN_W      = 32;
    localparam int MAJ_W       = 6;
    localparam int EXT_W       = 5;
    localparam int REG_W       = 5;
    localparam int BF_W        = 16;
    localparam int SP_W        = 32;
    localparam int SP_EXP_W    = 8;
    localparam int SP_FRAC_W   = 23;
    localparam int DP_W        = 64;
    localparam int DP_EXP_W    = 11;
    localparam int DP_FRAC_W   = 52;
    localparam int SP_BIAS     = 127;
    localparam int DP_BIAS     = 1023;
    localparam int BIAS_DELTA  = DP_BIAS - SP_BIAS;
    localparam int FRAC_PAD    = DP_FRAC_W - SP_FRAC_W;
    localparam int WIDEN_PAD   = SP_W - BF_W;

    // MSB-0 field positions
    localparam int MAJ_POS     = 0;
    localparam int REG_POS     = 6;
    localparam int IMM_LO_POS  = 11;
    localparam int IMM_LO_W    = 15;
    localparam int EXT_POS     = 26;
    localparam int IMM_HI_POS  = 31;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_fields_t;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dp_fields_t;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] fpr;
        logic [BF_W-1:0]  imm;
    } decoded_t;

    // LSB index of MSB-0 bit position p in an INSN_W-bit word
    function automatic int msb0(input int p);
        return INSN_W - 1 - p;
    endfunction

    function automatic fp_class_e classify(input sp_fields_t s);
        if (s.exp == '1)
            return (s.frac == '0) ? CLS_INF : CLS_NAN;
        else if (s.exp == '0)
            return (s.frac == '0) ? CLS_ZERO : CLS_SUBN;
        else
            return CLS_NORM;
    endfunction

endpackage

// File: rtl/bfimm_field_decode.sv
module bfimm_field_decode
    import bfimm_pkg::*;
#(
    parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd59,
    parameter logic [EXT_W-1:0] EXT_OP   = 5'd22
) (
    input  logic [INSN_W-1:0] word,
    output decoded_t          dec
);

    logic [MAJ_W-1:0]    maj_f;
    logic [EXT_W-1:0]    ext_f;
    logic [REG_W-1:0]    reg_f;
    logic [IMM_LO_W-1:0] imm_lo;

    genvar g;
    generate
        for (g = 0; g < MAJ_W; g++) begin : g_maj
            assign maj_f[MAJ_W-1-g] = word[msb0(MAJ_POS + g)];
        end
        for (g = 0; g < EXT_W; g++) begin : g_ext
            assign ext_f[EXT_W-1-g] = word[msb0(EXT_POS + g)];
        end
        for (g = 0; g < REG_W; g++) begin : g_reg
            assign reg_f[REG_W-1-g] = word[msb0(REG_POS + g)];
        end
        for (g = 0; g < IMM_LO_W; g++) begin : g_imm
            assign imm_lo[IMM_LO_W-1-g] = word[msb0(IMM_LO_POS + g)];
        end
    endgenerate

    always_comb begin
        dec.hit = (maj_f == MAJOR_OP) && (ext_f == EXT_OP);
        dec.fpr = reg_f;
        dec.imm = {word[msb0(IMM_HI_POS)], imm_lo};
    end

endmodule

// File: rtl/bfimm_lzc.sv
module bfimm_lzc #(
    parameter int WIDTH = 23,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        cnt = CNT_W'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i])
                cnt = CNT_W'(WIDTH - 1 - i);
        end
    end

endmodule

// File: rtl/bfimm_sp2dp.sv
module bfimm_sp2dp
    import bfimm_pkg::*;
(
    input  sp_fields_t sp,
    output dp_fields_t dp
);

    localparam int LZ_W = $clog2(SP_FRAC_W + 1);

    fp_class_e             cls;
    logic [LZ_W-1:0]       lz;
    logic [SP_FRAC_W:0]    sub_shift;
    logic [SP_FRAC_W-1:0]  sub_frac;
    logic [DP_EXP_W-1:0]   sub_exp;
    logic [DP_EXP_W-1:0]   norm_exp;

    bfimm_lzc #(.WIDTH(SP_FRAC_W)) lzc_i (
        .vec (sp.frac),
        .cnt (lz)
    );

    always_comb begin
        cls       = classify(sp);
        sub_shift = {sp.frac, 1'b0} << lz;
        sub_frac  = sub_shift[SP_FRAC_W-1:0];
        sub_exp   = DP_EXP_W'(BIAS_DELTA) - DP_EXP_W'(lz);
        norm_exp  = DP_EXP_W'(sp.exp) + DP_EXP_W'(BIAS_DELTA);

        dp.sign = sp.sign;
        unique case (cls)
            CLS_ZERO: begin
                dp.exp  = '0;
                dp.frac = '0;
            end
            CLS_SUBN: begin
                dp.exp  = sub_exp;
                dp.frac = {sub_frac, {FRAC_PAD{1'b0}}};
            end
            CLS_INF, CLS_NAN: begin
                dp.exp  = '1;
                dp.frac = {sp.frac, {FRAC_PAD{1'b0}}};
            end
            default: begin
                dp.exp  = norm_exp;
                dp.frac = {sp.frac, {FRAC_PAD{1'b0}}};
            end
        endcase
    end

endmodule

// File: rtl/bfimm_expander.sv
module bfimm_expander
    import bfimm_pkg::*;
#(
    parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd59,
    parameter logic [EXT_W-1:0] EXT_OP   = 5'd22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    output logic              res_valid,
    output logic [REG_W-1:0]  res_fpr,
    output logic [DP_W-1:0]   res_value
);

    decoded_t   dec;
    sp_fields_t sp;
    dp_fields_t dp;
    logic       accept;

    bfimm_field_decode #(
        .MAJOR_OP (MAJOR_OP),
        .EXT_OP   (EXT_OP)
    ) dec_i (
        .word (insn_word),
        .dec  (dec)
    );

    assign sp = sp_fields_t'({dec.imm, {WIDEN_PAD{1'b0}}});

    bfimm_sp2dp cvt_i (
        .sp (sp),
        .dp (dp)
    );

    assign accept = insn_valid && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fpr   <= '0;
            res_value <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_fpr   <= dec.fpr;
                res_value <= dp;
            end
        end
    end

endmodule

// File: rtl/bfimm_expander_chk.sv
module bfimm_expander_chk
    import bfimm_pkg::*;
#(
    parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd59,
    parameter logic [EXT_W-1:0] EXT_OP   = 5'd22
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_valid,
    input logic [INSN_W-1:0] insn_word,
    input logic              res_valid,
    input logic [REG_W-1:0]  res_fpr,
    input logic [DP_W-1:0]   res_value
);

    logic take;
    assign take = insn_valid && (insn_word[31:26] == MAJOR_OP)
                             && (insn_word[5:1] == EXT_OP);

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> res_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> !res_valid);

    assert_hold_value_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(res_value) && $stable(res_fpr)));

    assert_dest_reg_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> (res_fpr == $past(insn_word[25:21])));

    assert_sign_bit_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> (res_value[63] == $past(insn_word[0])));

    assert_exp_range_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_value[62:52] != '0 && res_value[62:52] != '1)
        |-> (res_value[62:52] >= 11'h37A && res_value[62:52] <= 11'h47E));

    assert_infinity_R8: assert property (@(posedge clk) disable iff (rst)
        (take && insn_word[20:13] == 8'hFF && insn_word[12:6] == '0)
        |=> (res_value[62:0] == 63'h7FF0_0000_0000_0000));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!res_valid && res_fpr == '0 && res_value == '0));

endmodule

bind bfimm_expander bfimm_expander_chk #(
    .MAJOR_OP (MAJOR_OP),
    .EXT_OP   (EXT_OP)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .res_valid  (res_valid),
    .res_fpr    (res_fpr),
    .res_value  (res_value)
);

// File: tb/bfimm_expander_tb_top.sv
module bfimm_expander_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [5:0] MAJ = 6'd59;
    localparam logic [4:0] EXT = 5'd22;
    localparam int N = 16;

    localparam logic [15:0] IMM_TAB [N] = '{
        16'h0000, 16'h8000, 16'h3F80, 16'hBF80,
        16'hBFC0, 16'h3FFF, 16'h7F80, 16'hFF80,
        16'h7FC0, 16'h7F81, 16'h7F7F, 16'h0080,
        16'h0040, 16'h0001, 16'h8041, 16'h4049
    };
    localparam logic [63:0] EXP_TAB [N] = '{
        64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
        64'hBFF8_0000_0000_0000, 64'h3FFF_E000_0000_0000,
        64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
        64'h7FF8_0000_0000_0000, 64'h7FF0_2000_0000_0000,
        64'h47EF_E000_0000_0000, 64'h3810_0000_0000_0000,
        64'h3800_0000_0000_0000, 64'h37A0_0000_0000_0000,
        64'hB800_4000_0000_0000, 64'h4009_2000_0000_0000
    };
    localparam logic [8*3-1:0] TAG_TAB [N] = '{
        "R6", "R6", "R5", "R5", "R5", "R5", "R8", "R8",
        "R9", "R9", "R5", "R5", "R7", "R7", "R7", "R4"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        res_valid;
    logic [4:0]  res_fpr;
    logic [63:0] res_value;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfimm_expander #(.MAJOR_OP(MAJ), .EXT_OP(EXT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .res_valid  (res_valid),
        .res_fpr    (res_fpr),
        .res_value  (res_value)
    );

    function automatic logic [31:0] mk_word(input logic [5:0] maj, input logic [4:0] fpr,
                                            input logic [15:0] imm, input logic [4:0] ext);
        logic [31:0] w;
        w[31:26] = maj;
        w[25:21] = fpr;
        w[20:6]  = imm[14:0];
        w[5:1]   = ext;
        w[0]     = imm[15];
        return w;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, clock once, sample at following negedge
    task automatic issue(input logic v, input logic [31:0] w);
        insn_valid = v;
        insn_word  = w;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10 valid", 64'(res_valid), 64'd0);
        check("R10 value", res_value, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < N; i++) begin
            issue(1'b1, mk_word(MAJ, 5'(i), IMM_TAB[i], EXT));
            check({TAG_TAB[i], " value"}, res_value, EXP_TAB[i]);
            check("R1 valid", 64'(res_valid), 64'd1);
            check("R3 fpr", 64'(res_fpr), 64'(i));
        end

        // R2: wrong major opcode ignored, value held
        held = res_value;
        issue(1'b1, mk_word(MAJ ^ 6'd1, 5'd9, 16'h3F80, EXT));
        check("R2 major valid", 64'(res_valid), 64'd0);
        check("R2 major hold", res_value, held);
        // R2: wrong extended opcode ignored
        issue(1'b1, mk_word(MAJ, 5'd9, 16'h3F80, EXT ^ 5'd16));
        check("R2 ext valid", 64'(res_valid), 64'd0);
        check("R2 ext hold", res_value, held);
        check("R2 fpr hold", 64'(res_fpr), 64'd15);
        // R2: matching word without insn_valid
        issue(1'b0, mk_word(MAJ, 5'd9, 16'h3F80, EXT));
        check("R2 novalid", 64'(res_valid), 64'd0);
        check("R2 novalid hold", res_value, held);

        // R1: back-to-back instructions
        insn_valid = 1'b1;
        insn_word  = mk_word(MAJ, 5'd3, 16'hBF80, EXT);
        @(negedge clk);
        check("R1 b2b first", res_value, 64'hBFF0_0000_0000_0000);
        insn_word  = mk_word(MAJ, 5'd31, 16'h7F80, EXT);
        @(negedge clk);
        insn_valid = 1'b0;
        check("R1 b2b second", res_value, 64'h7FF0_0000_0000_0000);
        check("R3 b2b fpr", 64'(res_fpr), 64'd31);
        @(negedge clk);
        check("R1 b2b drop", 64'(res_valid), 64'd0);

        // R4: immediate top bit only in bit 0 changes sign of +1.0
        issue(1'b1, {MAJ, 5'd1, 15'h3F80, EXT, 1'b1});
        check("R4 split sign", res_value, 64'hBFF0_0000_0000_0000);

        // R10: reset while result held
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid valid", 64'(res_valid), 64'd0);
        check("R10 mid value", res_value, 64'd0);
        check("R10 mid fpr", 64'(res_fpr), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule